// File: doc/BRIEF.md
# Dual-Direction Latched Bus Transceiver

The block passes data between an A side and a B side, in either direction, through a storage latch for each direction. The data path is split into sections of equal width, two sections of eight bits by default. Each section has its own control set, so the sections work as separate narrow transceivers. Tying their controls together makes them one wide path.

Every direction of every section takes three active-low controls: a chip enable, a latch enable and an output enable. The chip enable gates both the capture into the latch and the driver of that direction. The latch enable selects between following the input and holding a stored value. The output enable switches the driver. The tri-state pads are modelled as separate signals. Each port has an input bus, an output bus and a drive-enable bit for each section. A section that is not driven reads as zero on its output bus.

The latches are modelled as registers on the block clock with an explicit transparent bypass. A rise of the latch enable is detected at a clock edge, and the input present at that edge is stored.

Top module: `xcvr_latched_dual`

## Requirements
- R1: For a section, the B drive-enable bit is 1 exactly when that section's A-to-B chip enable and output enable are both 0. While the bit is 0, that section's bits of `b_out` read 0.
- R2: When a section's A-to-B chip enable and latch enable are both 0 and the driver is on, that section's `b_out` equals its `a_in` bits in the same cycle.
- R3: With the chip enable at 0, suppose a clock edge sees the latch enable at 1 and the previous edge saw it at 0. That edge stores the `a_in` value present at it. The value is then shown on `b_out` while the latch enable stays at 1.
- R4: While the latch enable stays at 1 across clock edges, the stored value does not change, whatever `a_in` does.
- R5: While the chip enable is 1, the latch ignores the latch enable and the data, and keeps its contents.
- R6: The sections are independent. Activity on the controls and data of one section leaves the outputs of the other section unchanged.
- R7: The B-to-A direction behaves like R1 to R5. It uses its own chip, latch and output enables, takes data from `b_in` and drives `a_out` and `a_drv`.
- R8: A synchronous active-high reset clears every latch to zero. The drive-enable bits follow the enable controls right after reset.
- R9: Both directions of one section may drive at the same time. The block does not arbitrate. Each port then shows its own direction's stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | SEC_W*N_SEC | Data arriving on the A side |
| b_in | input | SEC_W*N_SEC | Data arriving on the B side |
| ce_ab_n | input | N_SEC | A-to-B chip enable for each section, active low |
| le_ab_n | input | N_SEC | A-to-B latch enable for each section, active low |
| oe_ab_n | input | N_SEC | A-to-B output enable for each section, active low |
| ce_ba_n | input | N_SEC | B-to-A chip enable for each section, active low |
| le_ba_n | input | N_SEC | B-to-A latch enable for each section, active low |
| oe_ba_n | input | N_SEC | B-to-A output enable for each section, active low |
| a_out | output | SEC_W*N_SEC | Data driven onto the A side (zero where not driven) |
| a_drv | output | N_SEC | A-side drive enable for each section |
| b_out | output | SEC_W*N_SEC | Data driven onto the B side (zero where not driven) |
| b_drv | output | N_SEC | B-side drive enable for each section |

## Verification
Two of this block's functions can fall in the same cycle in a section: the A-to-B driver and the B-to-A driver. That is a bus conflict, and the block leaves it unresolved. The bench provokes it by enabling both chip enables and both output enables of one section while the latches hold. It flags the conflict, and it judges that each port still carries its own direction's stored value. A capture edge and a data change can also meet at one clock edge. The bench changes the data in the same half-cycle as it raises the latch enable, and it expects the later value to be stored.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int SEC_W_DEF = 8;
    localparam int N_SEC_DEF = 2;

    typedef struct packed {
        logic ce_n;
        logic le_n;
        logic oe_n;
    } dir_ctrl_t;

    function automatic logic ctl_transparent(dir_ctrl_t c);
        return !c.ce_n && !c.le_n;
    endfunction

    function automatic logic ctl_driving(dir_ctrl_t c);
        return !c.ce_n && !c.oe_n;
    endfunction

    function automatic logic ctl_capture(dir_ctrl_t c, logic le_prev_n);
        return !c.ce_n && (!c.le_n || !le_prev_n);
    endfunction

endpackage

// File: rtl/xcvr_dir_latch.sv
module xcvr_dir_latch
    import xcvr_pkg::*;
#(
    parameter int W = SEC_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  dir_ctrl_t    ctrl,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         drv
);

    logic [W-1:0] held_q;
    logic         le_prev_n_q;
    logic [W-1:0] view;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q      <= '0;
            le_prev_n_q <= 1'b1;
        end else begin
            le_prev_n_q <= ctrl.le_n;
            if (ctl_capture(ctrl, le_prev_n_q)) begin
                held_q <= din;
            end
        end
    end

    always_comb begin
        view = ctl_transparent(ctrl) ? din : held_q;
        drv  = ctl_driving(ctrl);
        dout = drv ? view : '0;
    end

endmodule

// File: rtl/xcvr_section.sv
module xcvr_section
    import xcvr_pkg::*;
#(
    parameter int W = SEC_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  dir_ctrl_t    ab_ctrl,
    input  dir_ctrl_t    ba_ctrl,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic         a_drv,
    output logic [W-1:0] b_out,
    output logic         b_drv
);

    xcvr_dir_latch #(.W(W)) ab_i (
        .clk  (clk),
        .rst  (rst),
        .ctrl (ab_ctrl),
        .din  (a_in),
        .dout (b_out),
        .drv  (b_drv)
    );

    xcvr_dir_latch #(.W(W)) ba_i (
        .clk  (clk),
        .rst  (rst),
        .ctrl (ba_ctrl),
        .din  (b_in),
        .dout (a_out),
        .drv  (a_drv)
    );

endmodule

// File: rtl/xcvr_latched_dual.sv
module xcvr_latched_dual
    import xcvr_pkg::*;
#(
    parameter  int SEC_W = SEC_W_DEF,
    parameter  int N_SEC = N_SEC_DEF,
    localparam int DW    = SEC_W * N_SEC
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [DW-1:0]   a_in,
    input  logic [DW-1:0]   b_in,
    input  logic [N_SEC-1:0] ce_ab_n,
    input  logic [N_SEC-1:0] le_ab_n,
    input  logic [N_SEC-1:0] oe_ab_n,
    input  logic [N_SEC-1:0] ce_ba_n,
    input  logic [N_SEC-1:0] le_ba_n,
    input  logic [N_SEC-1:0] oe_ba_n,
    output logic [DW-1:0]   a_out,
    output logic [N_SEC-1:0] a_drv,
    output logic [DW-1:0]   b_out,
    output logic [N_SEC-1:0] b_drv
);

    for (genvar s = 0; s < N_SEC; s++) begin : g_sec
        dir_ctrl_t ab_c;
        dir_ctrl_t ba_c;

        always_comb begin
            ab_c = '{ce_n: ce_ab_n[s], le_n: le_ab_n[s], oe_n: oe_ab_n[s]};
            ba_c = '{ce_n: ce_ba_n[s], le_n: le_ba_n[s], oe_n: oe_ba_n[s]};
        end

        xcvr_section #(.W(SEC_W)) sec_i (
            .clk     (clk),
            .rst     (rst),
            .ab_ctrl (ab_c),
            .ba_ctrl (ba_c),
            .a_in    (a_in[s*SEC_W +: SEC_W]),
            .b_in    (b_in[s*SEC_W +: SEC_W]),
            .a_out   (a_out[s*SEC_W +: SEC_W]),
            .a_drv   (a_drv[s]),
            .b_out   (b_out[s*SEC_W +: SEC_W]),
            .b_drv   (b_drv[s])
        );
    end

endmodule

// File: rtl/xcvr_latched_dual_chk.sv
module xcvr_latched_dual_chk #(
    parameter  int SEC_W = 8,
    parameter  int N_SEC = 2,
    localparam int DW    = SEC_W * N_SEC
) (
    input logic             clk,
    input logic             rst,
    input logic [DW-1:0]    a_in,
    input logic [DW-1:0]    b_in,
    input logic [N_SEC-1:0] ce_ab_n,
    input logic [N_SEC-1:0] le_ab_n,
    input logic [N_SEC-1:0] oe_ab_n,
    input logic [N_SEC-1:0] ce_ba_n,
    input logic [N_SEC-1:0] le_ba_n,
    input logic [N_SEC-1:0] oe_ba_n,
    input logic [DW-1:0]    a_out,
    input logic [N_SEC-1:0] a_drv,
    input logic [DW-1:0]    b_out,
    input logic [N_SEC-1:0] b_drv
);

    logic [1:0] warm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            warm_q <= '0;
        end else if (warm_q != 2'd3) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    for (genvar s = 0; s < N_SEC; s++) begin : g_chk
        p_ab_drive_rule_r1: assert property (@(posedge clk) disable iff (rst)
            b_drv[s] == (!ce_ab_n[s] && !oe_ab_n[s]));

        p_ab_idle_zero_r1: assert property (@(posedge clk) disable iff (rst)
            !b_drv[s] |-> (b_out[s*SEC_W +: SEC_W] == '0));

        p_ab_transparent_r2: assert property (@(posedge clk) disable iff (rst)
            (b_drv[s] && !le_ab_n[s]) |-> (b_out[s*SEC_W +: SEC_W] == a_in[s*SEC_W +: SEC_W]));

        p_ab_hold_r4: assert property (@(posedge clk) disable iff (rst)
            (warm_q[1] && b_drv[s] && $past(b_drv[s]) && le_ab_n[s]
             && $past(le_ab_n[s]) && $past(le_ab_n[s], 2))
            |-> (b_out[s*SEC_W +: SEC_W] == $past(b_out[s*SEC_W +: SEC_W])));

        p_ba_drive_rule_r7: assert property (@(posedge clk) disable iff (rst)
            a_drv[s] == (!ce_ba_n[s] && !oe_ba_n[s]));

        p_ba_transparent_r7: assert property (@(posedge clk) disable iff (rst)
            (a_drv[s] && !le_ba_n[s]) |-> (a_out[s*SEC_W +: SEC_W] == b_in[s*SEC_W +: SEC_W]));
    end

endmodule

bind xcvr_latched_dual xcvr_latched_dual_chk #(.SEC_W(SEC_W), .N_SEC(N_SEC)) chk_i (.*);

// File: tb/xcvr_latched_dual_tb_top.sv
module xcvr_latched_dual_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SW = 8;
    localparam int NS = 2;
    localparam int DW = SW * NS;

    logic          clk = 1'b0;
    logic          rst;
    logic [DW-1:0] a_in, b_in, a_out, b_out;
    logic [NS-1:0] ce_ab_n, le_ab_n, oe_ab_n, ce_ba_n, le_ba_n, oe_ba_n;
    logic [NS-1:0] a_drv, b_drv;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] held [2][2];

    always #(CLK_PERIOD/2) clk = ~clk;

    xcvr_latched_dual #(.SEC_W(SW), .N_SEC(NS)) dut_i (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .ce_ab_n(ce_ab_n), .le_ab_n(le_ab_n), .oe_ab_n(oe_ab_n),
        .ce_ba_n(ce_ba_n), .le_ba_n(le_ba_n), .oe_ba_n(oe_ba_n),
        .a_out(a_out), .a_drv(a_drv), .b_out(b_out), .b_drv(b_drv)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_ctl(int s, bit dir, bit ce, bit le, bit oe);
        if (!dir) begin
            ce_ab_n[s] = ce; le_ab_n[s] = le; oe_ab_n[s] = oe;
        end else begin
            ce_ba_n[s] = ce; le_ba_n[s] = le; oe_ba_n[s] = oe;
        end
    endtask

    task automatic set_data(int s, bit dir, logic [7:0] v);
        if (!dir) a_in[s*SW +: SW] = v;
        else      b_in[s*SW +: SW] = v;
    endtask

    function automatic logic [7:0] get_out(int s, bit dir);
        return dir ? a_out[s*SW +: SW] : b_out[s*SW +: SW];
    endfunction

    function automatic logic get_drv(int s, bit dir);
        return dir ? a_drv[s] : b_drv[s];
    endfunction

    // transparent phase, then latch enable rises together with the final data
    task automatic store(int s, bit dir, logic [7:0] v, logic [7:0] decoy);
        @(negedge clk);
        set_ctl(s, dir, 1'b0, 1'b0, 1'b1);
        set_data(s, dir, 8'h00);
        @(negedge clk);
        set_ctl(s, dir, 1'b0, 1'b1, 1'b1);
        set_data(s, dir, v);
        @(negedge clk);
        set_data(s, dir, decoy);
        held[s][dir] = v;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1;
        a_in = '0; b_in = '0;
        ce_ab_n = '1; le_ab_n = '1; oe_ab_n = '1;
        ce_ba_n = '1; le_ba_n = '1; oe_ba_n = '1;
        repeat (3) @(negedge clk);
        ce_ab_n = '0; oe_ab_n = '0; ce_ba_n = '0; oe_ba_n = '0;
        a_in = 16'hFFFF; b_in = 16'hFFFF;
        rst = 1'b0;
        #1;
        // R8: drives follow enables immediately, latches read zero
        check("R8 b_drv after reset", b_drv, 2'b11);
        check("R8 a_drv after reset", a_drv, 2'b11);
        check("R8 b_out after reset", b_out, 16'h0000);
        check("R8 a_out after reset", a_out, 16'h0000);
        ce_ab_n = '1; oe_ab_n = '1; ce_ba_n = '1; oe_ba_n = '1;

        store(0, 1'b0, 8'h3C, 8'hAA);
        store(1, 1'b0, 8'hC3, 8'h55);
        store(0, 1'b1, 8'h69, 8'h12);
        store(1, 1'b1, 8'h96, 8'h34);

        // R3 and R7: stored value visible with the latch enable high
        @(negedge clk);
        oe_ab_n = '0; oe_ba_n = '0;
        #1;
        check("R3 sec0 stored", get_out(0, 1'b0), 8'h3C);
        check("R3 sec1 stored", get_out(1, 1'b0), 8'hC3);
        check("R7 sec0 stored", get_out(0, 1'b1), 8'h69);
        check("R7 sec1 stored", get_out(1, 1'b1), 8'h96);

        // R4: data changes while the latch enable stays high
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            a_in = 16'h1111 * (k + 3);
            b_in = 16'h2222 * (k + 1);
            #1;
            check("R4 AB hold", b_out, 16'hC33C);
            check("R4 BA hold", a_out, 16'h9669);
        end
        ce_ab_n = '1; ce_ba_n = '1; oe_ab_n = '1; oe_ba_n = '1;

        // R1 and R2 sweep: every control combination, several data patterns
        for (int s = 0; s < NS; s++) begin
            for (int d = 0; d < 2; d++) begin
                for (int c = 0; c < 8; c++) begin
                    for (int p = 0; p < 4; p++) begin
                        logic [7:0] pat;
                        logic       e_drv;
                        logic [7:0] e_out;
                        pat = 8'h5A ^ (8'h37 * p[7:0]) ^ {4'h0, c[3:0]};
                        @(negedge clk);
                        set_data(s, d[0], pat);
                        set_ctl(s, d[0], c[2], c[1], c[0]);
                        #1;
                        e_drv = !c[2] && !c[0];
                        e_out = !e_drv ? 8'h00 : ((!c[2] && !c[1]) ? pat : held[s][d]);
                        if (d == 0) begin
                            check("R1 AB drive", get_drv(s, 1'b0), e_drv);
                            check("R2 AB out", get_out(s, 1'b0), e_out);
                        end else begin
                            check("R7 BA drive", get_drv(s, 1'b1), e_drv);
                            check("R7 BA out", get_out(s, 1'b1), e_out);
                        end
                        #1;
                        set_ctl(s, d[0], 1'b1, 1'b1, 1'b1);
                    end
                end
            end
        end

        // R5: latch enable pulses and data changes while the chip enable is high
        @(negedge clk);
        set_ctl(0, 1'b0, 1'b1, 1'b0, 1'b1);
        set_data(0, 1'b0, 8'hEE);
        @(negedge clk);
        set_ctl(0, 1'b0, 1'b1, 1'b1, 1'b1);
        set_data(0, 1'b0, 8'h11);
        @(negedge clk);
        set_ctl(0, 1'b0, 1'b0, 1'b1, 1'b0);
        #1;
        check("R5 AB ignores LE while CE high", get_out(0, 1'b0), 8'h3C);

        // R6: section 1 transparent and driving, section 0 holding
        @(negedge clk);
        set_ctl(1, 1'b0, 1'b0, 1'b0, 1'b0);
        set_data(1, 1'b0, 8'h77);
        @(negedge clk);
        set_data(1, 1'b0, 8'h78);
        #1;
        check("R6 sec1 follows", get_out(1, 1'b0), 8'h78);
        check("R6 sec0 untouched", get_out(0, 1'b0), 8'h3C);
        set_ctl(1, 1'b0, 1'b1, 1'b1, 1'b1);

        // R9: both directions of section 0 driving
        @(negedge clk);
        set_ctl(0, 1'b1, 1'b0, 1'b1, 1'b0);
        #1;
        if (a_drv[0] && b_drv[0])
            $display("note: bus conflict flagged on section 0");
        check("R9 both drives on", {a_drv[0], b_drv[0]}, 2'b11);
        check("R9 B side keeps AB value", get_out(0, 1'b0), 8'h3C);
        check("R9 A side keeps BA value", get_out(0, 1'b1), 8'h69);

        // R8: reset in mid-run clears the latches
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R8 AB cleared", get_out(0, 1'b0), 8'h00);
        check("R8 BA cleared", get_out(0, 1'b1), 8'h00);

        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule